// File: doc/BRIEF.md
# Sub-Cycle Dithered PWM Generator

This block produces one or two pulse-width modulated outputs with 8-bit average duty resolution, clocked straight from the system clock. A 256-clock PWM cycle is cut into four 64-clock sub-cycles. The six high bits of a channel's duty value give every sub-cycle the same base high time. The two low bits pick how many of the leading sub-cycles get one more high clock. The waveform therefore repeats at a quarter of the full cycle length. This makes the pulses four times more frequent and easier for a slow load to average, while the total high time over a full cycle still equals the 8-bit value.

Duty values arrive on a small valid/ready write port that carries a channel index. A written value lands in a per-channel holding register. It becomes active only at the first clock of sub-cycle 0, so one 256-clock cycle never mixes two values. The port applies no back-pressure: ready is high whenever reset is low, and a transfer happens on any clock where valid and ready are both high. An enable input stops the shared counter at zero and forces every output low. When enable returns, counting restarts at sub-cycle 0.

Top module: `subcycle_pwm`

## Requirements
- R1: While reset is high and on the first clock after it, every PWM output is low. The held and active duty values of every channel are cleared to 0.
- R2: The output is registered. Let n be the shared counter value, with sub-cycle index i = n[7:6] and position p = n[5:0]. One clock after count n, the output is high exactly when p < base + (1 if i < extra else 0). So each sub-cycle starts high at position 0.
- R3: The duty value splits as base = bits [7:2] and extra = bits [1:0]. Over any full 256-clock cycle, the number of high output clocks equals the 8-bit duty value.
- R4: A duty value of 0 gives an output that stays low for the whole cycle.
- R5: When base is 63 and the sub-cycle gets the extra clock, the output is high for all 64 clocks of that sub-cycle. Example: value 255 keeps sub-cycles 0 to 2 fully high, and sub-cycle 3 is high for 63 clocks.
- R6: A value written while counting takes effect at the next count 0, not before. A write accepted on the same clock as count 0 waits for the following cycle.
- R7: When enable is low, the counter holds at 0 and every output is low from the next clock on. After enable rises, the first clock counts position 0 of sub-cycle 0.
- R8: Channels are independent. A write to one channel index (wr_chan) changes only that channel's output.
- R9: wr_ready is low while reset is high and high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the PWM time base |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds counter at 0 and outputs low |
| wr_valid | input | 1 | Duty write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_chan | input | CH_W | Channel index of the write |
| wr_duty | input | 8 | New 8-bit duty value |
| pwm_out | output | NUM_CH | PWM outputs, one per channel |

## Verification
Several properties are checked on every clock. The counter holds at zero while disabled and wraps from 255 to 0. The active duty value stays unchanged except at count 0. Every output goes low one clock after enable falls, and stays low for a zero value. Each output is high at the start of sub-cycle 0 for any nonzero value, and fills the last position of a sub-cycle that has base 63 with the extra clock. The exact high length of each sub-cycle, the per-cycle total equal to the duty value, and the deferral of mid-cycle writes to the next cycle boundary are shown only by the bench scenarios. The same holds for channel independence and the restart at sub-cycle 0 after a pause. There the bench compares every output clock against a model built from the duty split.

// File: rtl/subpwm_pkg.sv
package subpwm_pkg;
  localparam int DUTY_W = 8;
  localparam int SUB_W  = 2;
  localparam int POS_W  = DUTY_W - SUB_W;

  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [SUB_W-1:0]  sub_idx_t;
  typedef logic [POS_W-1:0]  pos_t;

  typedef struct packed {
    pos_t     base;
    sub_idx_t extra;
  } duty_split_t;

  // high-time threshold of one sub-cycle, one bit wider than a position
  function automatic logic [POS_W:0] sub_threshold(duty_split_t d, sub_idx_t idx);
    logic bump;
    bump = (idx < d.extra);
    return {1'b0, d.base} + {{POS_W{1'b0}}, bump};
  endfunction
endpackage

// File: rtl/subpwm_cycle_cnt.sv
module subpwm_cycle_cnt
  import subpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output duty_t cnt,
  output logic  cycle_start
);
  duty_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else            cnt_q <= cnt_q + {{(DUTY_W-1){1'b0}}, 1'b1};
  end

  assign cnt         = cnt_q;
  assign cycle_start = (cnt_q == '0);

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q == '1) |=> cnt_q == '0);
endmodule

// File: rtl/subpwm_duty_hold.sv
module subpwm_duty_hold
  import subpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  duty_t load_val,
  input  logic  cycle_start,
  output duty_t duty_eff
);
  duty_t shadow_q;
  duty_t active_q;

  always_ff @(posedge clk) begin
    if (rst)       shadow_q <= '0;
    else if (load) shadow_q <= load_val;
  end

  always_ff @(posedge clk) begin
    if (rst)              active_q <= '0;
    else if (cycle_start) active_q <= shadow_q;
  end

  // at count 0 the held value is used at once; elsewhere the latched copy
  assign duty_eff = cycle_start ? shadow_q : active_q;

  // R6
  active_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cycle_start |=> $stable(active_q));
endmodule

// File: rtl/subpwm_chan_out.sv
module subpwm_chan_out
  import subpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  duty_t cnt,
  input  duty_t duty_eff,
  output logic  pwm
);
  sub_idx_t         idx;
  pos_t             pos;
  duty_split_t      split;
  logic [POS_W:0]   thr;
  logic             hit;
  logic             pwm_q;

  assign idx   = cnt[DUTY_W-1 -: SUB_W];
  assign pos   = cnt[POS_W-1:0];
  assign split = duty_split_t'(duty_eff);
  assign thr   = sub_threshold(split, idx);
  assign hit   = ({1'b0, pos} < thr);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en & hit;
  end

  assign pwm = pwm_q;

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_q);

  // R4
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && duty_eff == '0) |=> !pwm_q);

  // R2
  rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == '0 && duty_eff != '0) |=> pwm_q);

  // R5
  full_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pos == '1 && split.base == '1 && idx < split.extra) |=> pwm_q);
endmodule

// File: rtl/subcycle_pwm.sv
module subcycle_pwm
  import subpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DUTY_W-1:0] wr_duty,
  output logic [NUM_CH-1:0] pwm_out
);
  duty_t cnt;
  logic  cycle_start;
  logic  wr_fire;

  assign wr_ready = ~rst;
  assign wr_fire  = wr_valid & wr_ready;

  subpwm_cycle_cnt u_cnt (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .cnt         (cnt),
    .cycle_start (cycle_start)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    duty_t duty_eff;
    logic  sel;

    assign sel = wr_fire && (wr_chan == CH_W'(g));

    subpwm_duty_hold u_hold (
      .clk         (clk),
      .rst         (rst),
      .load        (sel),
      .load_val    (wr_duty),
      .cycle_start (cycle_start),
      .duty_eff    (duty_eff)
    );

    subpwm_chan_out u_out (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .cnt      (cnt),
      .duty_eff (duty_eff),
      .pwm      (pwm_out[g])
    );
  end

  // R9
  ready_rst_chk: assert property (@(posedge clk) rst |-> !wr_ready);
endmodule

// File: tb/subcycle_pwm_bench.sv
module subcycle_pwm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [0:0] wr_chan = 1'b0;
  logic [7:0] wr_duty = 8'd0;
  logic [1:0] pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_cur  [2];
  logic [7:0] m_pend [2];
  int         hsum   [2];

  always #5 clk = ~clk;

  subcycle_pwm #(.NUM_CH(2)) u_subcycle_pwm (
    .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_duty(wr_duty), .pwm_out(pwm_out)
  );

  function automatic logic want_high(logic [7:0] v, int n);
    int sub, p, len;
    sub = (n % 256) / 64;
    p   = n % 64;
    len = int'(v >> 2);
    if (sub < int'(v & 8'h3)) len = len + 1;
    return (p < len);
  endfunction

  function automatic string tag_for(logic [7:0] v, string dflt);
    if (v == 8'd0) return "R4";
    if (v[7:2] == 6'h3f && v[1:0] != 2'd0) return "R5";
    return dflt;
  endfunction

  task automatic check(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic check_int(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // write while stopped (caller at negedge)
  task automatic write_idle(int ch, logic [7:0] v);
    wr_valid = 1'b1; wr_chan = ch[0]; wr_duty = v;
    @(posedge clk);
    m_pend[ch] = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // enable and run ncyc counts from 0; optional write at step wr_at
  task automatic run(int ncyc, int wr_at, int wr_ch, logic [7:0] wr_val, string tag);
    en = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      if (n == wr_at) begin
        wr_valid = 1'b1; wr_chan = wr_ch[0]; wr_duty = wr_val;
      end
      @(posedge clk);
      if (n % 256 == 0) begin
        for (int c = 0; c < 2; c++) begin m_cur[c] = m_pend[c]; hsum[c] = 0; end
      end
      if (n == wr_at) m_pend[wr_ch] = wr_val;
      @(negedge clk);
      wr_valid = 1'b0;
      for (int c = 0; c < 2; c++) begin
        check(tag_for(m_cur[c], tag), pwm_out[c], want_high(m_cur[c], n),
              $sformatf("ch%0d count %0d duty %0d", c, n, m_cur[c]));
        if (pwm_out[c] === 1'b1) hsum[c]++;
        if (n % 256 == 255)
          check_int("R3", hsum[c], int'(m_cur[c]),
                    $sformatf("ch%0d high clocks per cycle", c));
      end
    end
  endtask

  task automatic stop(int hold);
    en = 1'b0;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7", pwm_out[0], 1'b0, "ch0 while disabled");
      check("R7", pwm_out[1], 1'b0, "ch1 while disabled");
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin m_cur[c] = 0; m_pend[c] = 0; hsum[c] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", wr_ready, 1'b0, "ready during reset");
    check("R1", pwm_out[0], 1'b0, "ch0 during reset");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9", wr_ready, 1'b1, "ready after reset");
    check("R1", pwm_out[0], 1'b0, "ch0 after reset");
    check("R1", pwm_out[1], 1'b0, "ch1 after reset");

    // R1: cleared values give a low output when run without writes
    run(256, -1, 0, 8'd0, "R1");
    stop(2);

    // R2/R5: corner values on both channels
    write_idle(0, 8'd255); write_idle(1, 8'd253);
    run(512, -1, 0, 8'd0, "R5");
    stop(2);
    write_idle(0, 8'd1); write_idle(1, 8'd80);
    run(256, -1, 0, 8'd0, "R2");
    stop(2);
    write_idle(0, 8'd0); write_idle(1, 8'd252);
    run(256, -1, 0, 8'd0, "R4");
    stop(2);

    // R6: mid-cycle write deferred; write on count 0 waits a cycle
    write_idle(0, 8'd40); write_idle(1, 8'd200);
    run(512, 100, 0, 8'd171, "R6");
    run(512, 256, 1, 8'd7, "R6");
    stop(3);

    // R8: write only ch1, ch0 keeps its value
    write_idle(1, 8'd130);
    run(256, 50, 1, 8'd66, "R8");

    // R7: pause mid-cycle, restart from sub-cycle 0
    stop(5);
    run(300, -1, 0, 8'd0, "R7");
    stop(1);

    // random values with random mid-run writes
    for (int r = 0; r < 30; r++) begin
      write_idle(0, 8'($urandom_range(0, 255)));
      write_idle(1, 8'($urandom_range(0, 255)));
      run(512, $urandom_range(0, 511), $urandom_range(0, 1),
          8'($urandom_range(0, 255)), "R2");
      stop(1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule